// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This block holds four independent down-counters behind a small word-addressed register port. Each channel keeps a reload value and a live remaining count; while it is enabled, its remaining count falls by one on every clock. When a channel runs out it emits a one-cycle event on a wide interrupt-cause vector, so an external cause register can latch it. Each channel either runs periodically, reloading and continuing, or as a one-shot that stops at zero.

Software loads a channel by writing its count word while the channel is stopped. It starts, stops and picks modes through a single shared control word. A stopped channel keeps its remaining count, so enabling it again resumes where it left off. A channel that is enabled with nothing left to count first reloads. Channel 0 counts over a full 32 bits; the other three keep only 24.

Word map: addresses 0 to 3 are the count words of channels 0 to 3, address 4 is the control word, and every other address reads as zero.

Top module: `quad_timer`

## Requirements
- R1: After reset, every count word and the control word read zero and no cause bit is set.
- R2: Channel 0 keeps all 32 bits of a count write; channels 1 to 3 keep only bits 23:0, so the upper 8 bits read zero.
- R3: A count write to a stopped channel sets both its reload value and its live remaining count, which reads back on the next cycle.
- R4: A count write to a running channel changes neither its live count nor its reload value.
- R5: Reading a count word returns the live remaining count, which drops by exactly one per clock while the channel is enabled.
- R6: Setting a channel's enable bit while its remaining count is zero loads the reload value first; with a nonzero remainder it resumes from that remainder.
- R7: Clearing a running channel's enable bit freezes the remaining count on the same edge, and the count stays frozen until the channel is enabled again.
- R8: In periodic mode a channel that reaches zero reloads and keeps running, so a reload value of N gives one event every N cycles while its enable bit stays set.
- R9: In one-shot mode a channel that reaches zero stops, its remaining count reads zero, and its enable bit in the control word reads back as cleared.
- R10: Expiry of channel n raises bit 8+n of the cause output for exactly one cycle per expiry; no other cause bit is ever set.
- R11: In the control word, bit 2n is channel n's enable and bit 2n+1 selects periodic (1) or one-shot (0); bits 31:8 of the control word and all unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the addressed word |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| cause_evt | output | 32 | Expiry event pulses, channel n on bit 8+n |

## Verification
The hardest cases to reach are those where a control write meets a running channel on the same cycle: an enable or disable that lands on the expiring edge, and a count write issued while the channel is still counting. Directed sequences walk one channel through load, one-shot expiry, re-enable from zero, freeze and resume, and a periodic run, with cycle-exact expected values. A long random phase then fires control and count writes at channels that hold small reload values. This makes expiries collide often with writes, and every cycle's read data and cause vector are compared against a reference model built from the requirements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned REG_W = 32;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic periodic;
        logic en;
    } ch_ctl_t;

    function automatic ch_ctl_t ctl_field(input logic [REG_W-1:0] w, input int unsigned ch);
        ch_ctl_t c;
        c.en       = w[2*ch];
        c.periodic = w[2*ch+1];
        return c;
    endfunction

endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 3,
    localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  idx,
    output logic [NUM_CH-1:0] cnt_we,
    output logic              ctl_we
);

    always_comb begin
        idx = addr[IDX_W-1:0];
        if (addr < ADDR_W'(NUM_CH)) begin
            sel = SEL_COUNT;
        end else if (addr == ADDR_W'(NUM_CH)) begin
            sel = SEL_CTRL;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        for (int i = 0; i < int'(NUM_CH); i++) begin
            cnt_we[i] = we && (sel == SEL_COUNT) && (idx == IDX_W'(i));
        end
        ctl_we = we && (sel == SEL_CTRL);
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned CW = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_we,
    input  logic [CW-1:0]    cnt_wdata,
    input  logic             ctl_we,
    input  ch_ctl_t          ctl_new,
    output logic [REG_W-1:0] remain_o,
    output ch_ctl_t          ctl_o,
    output logic             expire_o
);

    logic [CW-1:0] remain;
    logic [CW-1:0] reload;
    logic          en;
    logic          per;
    logic          expire_q;

    logic en_rise, en_fall, running, at_end;

    always_comb begin
        en_rise = ctl_we && ctl_new.en && !en;
        en_fall = ctl_we && !ctl_new.en && en;
        running = en && !en_fall;
        at_end  = (remain == '0) || (remain == CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            remain   <= '0;
            reload   <= '0;
            en       <= 1'b0;
            per      <= 1'b0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (cnt_we && !en) begin
                reload <= cnt_wdata;
                remain <= cnt_wdata;
            end
            if (ctl_we) begin
                en  <= ctl_new.en;
                per <= ctl_new.periodic;
                if (en_rise && remain == '0) begin
                    remain <= reload;
                end
            end
            if (running) begin
                if (at_end) begin
                    expire_q <= 1'b1;
                    if (per) begin
                        remain <= reload;
                    end else begin
                        remain <= '0;
                        en     <= 1'b0;
                    end
                end else begin
                    remain <= remain - CW'(1);
                end
            end
        end
    end

    assign remain_o       = REG_W'(remain);
    assign ctl_o.en       = en;
    assign ctl_o.periodic = per;
    assign expire_o       = expire_q;

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!en && !cnt_we && !ctl_we) |=> $stable(remain));

    assert_run_dec_R5: assert property (@(posedge clk) disable iff (rst)
        (en && !ctl_we && remain > CW'(1)) |=> (remain == $past(remain) - CW'(1)));

    assert_oneshot_stop_R9: assert property (@(posedge clk) disable iff (rst)
        (en && !ctl_we && !per && remain == CW'(1)) |=> (!en && remain == '0 && expire_q));

    assert_periodic_reload_R8: assert property (@(posedge clk) disable iff (rst)
        (en && !ctl_we && per && remain == CW'(1)) |=> (en && expire_q && remain == $past(reload)));

    assert_busy_write_R4: assert property (@(posedge clk) disable iff (rst)
        (en && cnt_we) |=> $stable(reload));

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  reg_sel_e                     sel,
    input  logic [IDX_W-1:0]             idx,
    input  logic [NUM_CH-1:0][REG_W-1:0] counts,
    input  logic [2*NUM_CH-1:0]          ctl_vec,
    output logic [REG_W-1:0]             rdata
);

    always_comb begin
        unique case (sel)
            SEL_COUNT: rdata = counts[idx];
            SEL_CTRL:  rdata = REG_W'(ctl_vec);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/quad_timer.sv
module quad_timer
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CH     = 4,
    parameter int unsigned WIDE_W     = 32,
    parameter int unsigned NARROW_W   = 24,
    parameter int unsigned ADDR_W     = 3,
    parameter int unsigned CAUSE_BASE = 8,
    parameter int unsigned CAUSE_W    = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic [CAUSE_W-1:0] cause_evt
);

    localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    reg_sel_e                     sel;
    logic [IDX_W-1:0]             idx;
    logic [NUM_CH-1:0]            cnt_we;
    logic                         ctl_we;
    logic [NUM_CH-1:0][REG_W-1:0] counts;
    logic [2*NUM_CH-1:0]          ctl_vec;
    logic [NUM_CH-1:0]            expire;

    tmr_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .we     (reg_we),
        .addr   (reg_addr),
        .sel    (sel),
        .idx    (idx),
        .cnt_we (cnt_we),
        .ctl_we (ctl_we)
    );

    for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
        localparam int unsigned CW = (g == 0) ? WIDE_W : NARROW_W;
        ch_ctl_t ctl_q;

        tmr_channel #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .cnt_we    (cnt_we[g]),
            .cnt_wdata (reg_wdata[CW-1:0]),
            .ctl_we    (ctl_we),
            .ctl_new   (ctl_field(reg_wdata, g)),
            .remain_o  (counts[g]),
            .ctl_o     (ctl_q),
            .expire_o  (expire[g])
        );

        assign ctl_vec[2*g]   = ctl_q.en;
        assign ctl_vec[2*g+1] = ctl_q.periodic;
    end

    tmr_rdmux #(.NUM_CH(NUM_CH)) u_rd (
        .sel     (sel),
        .idx     (idx),
        .counts  (counts),
        .ctl_vec (ctl_vec),
        .rdata   (reg_rdata)
    );

    always_comb begin
        cause_evt = '0;
        for (int i = 0; i < int'(NUM_CH); i++) begin
            cause_evt[CAUSE_BASE + i] = expire[i];
        end
    end

    assert_cause_follows_ctl_R10: assert property (@(posedge clk) disable iff (rst)
        (|cause_evt) |-> $past(|ctl_vec));

endmodule

// File: tb/quad_timer_tb.sv
`timescale 1ns/1ps
module quad_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] cause_evt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] m_rem [4];
    logic [31:0] m_rld [4];
    bit          m_en  [4];
    bit          m_per [4];
    logic [31:0] m_evt;
    logic [31:0] last_rd;
    logic [31:0] last_evt;

    always #10 clk = ~clk;

    quad_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cause_evt (cause_evt)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wmask(input int ch, input logic [31:0] v);
        return (ch == 0) ? v : (v & 32'h00FF_FFFF);
    endfunction

    function automatic logic [31:0] mread(input int a);
        logic [31:0] c = '0;
        if (a < 4) return m_rem[a];
        if (a == 4) begin
            for (int i = 0; i < 4; i++) begin
                c[2*i]   = m_en[i];
                c[2*i+1] = m_per[i];
            end
            return c;
        end
        return '0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_rem[i] = '0; m_rld[i] = '0; m_en[i] = 0; m_per[i] = 0;
        end
        m_evt = '0;
    endtask

    task automatic model_step(input bit we, input int a, input logic [31:0] d);
        logic [31:0] nevt = '0;
        for (int i = 0; i < 4; i++) begin
            bit tw   = we && (a == 4);
            bit rise = tw && d[2*i] && !m_en[i];
            bit fall = tw && !d[2*i] && m_en[i];
            bit run  = m_en[i] && !fall;
            bit oper = m_per[i];
            logic [31:0] orem = m_rem[i];
            if (we && a == i && !m_en[i]) begin
                m_rld[i] = wmask(i, d);
                m_rem[i] = wmask(i, d);
            end
            if (tw) begin
                m_en[i]  = d[2*i];
                m_per[i] = d[2*i+1];
                if (rise && orem == 0) m_rem[i] = m_rld[i];
            end
            if (run) begin
                if (orem <= 1) begin
                    nevt[8+i] = 1'b1;
                    if (oper) m_rem[i] = m_rld[i];
                    else begin
                        m_rem[i] = '0;
                        m_en[i]  = 0;
                    end
                end else begin
                    m_rem[i] = orem - 1;
                end
            end
        end
        m_evt = nevt;
    endtask

    // One bus cycle: drive, sample the read and cause vector against the model, then clock.
    task automatic cyc(input bit we, input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = we; reg_addr = 3'(a); reg_wdata = d;
        #1;
        last_rd  = reg_rdata;
        last_evt = cause_evt;
        chk(reg_rdata == mread(a), "R5 live read", reg_rdata, mread(a));
        chk(cause_evt == m_evt, "R10 cause vector", cause_evt, m_evt);
        @(posedge clk);
        model_step(we, a, d);
    endtask

    task automatic peek(input int a, output logic [31:0] v);
        cyc(1'b0, a, 32'h0);
        v = last_rd;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %08h expected %08h", 32'h1, 32'h0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int hit_k;
        logic [31:0] hit_v;
        int prev_hit, n_hit;
        bit gaps_ok;

        void'($urandom(32'd1234));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            peek(a, v);
            chk(v == 32'h0, "R1 reset read", v, 32'h0);
        end
        chk(cause_evt == 32'h0, "R1 reset cause", cause_evt, 32'h0);

        // R2 and R3: widths and loads into stopped channels
        cyc(1'b1, 0, 32'hDEAD_BEEF);
        peek(0, v);
        chk(v == 32'hDEAD_BEEF, "R2 ch0 full width", v, 32'hDEAD_BEEF);
        cyc(1'b1, 1, 32'hAB12_3456);
        peek(1, v);
        chk(v == 32'h0012_3456, "R2 ch1 24-bit", v, 32'h0012_3456);
        cyc(1'b1, 1, 32'd10);
        peek(1, v);
        chk(v == 32'd10, "R3 stopped load", v, 32'd10);

        // R5: one-shot run of channel 1
        cyc(1'b1, 4, 32'h0000_0004);
        peek(1, v); chk(v == 32'd10, "R5 first", v, 32'd10);
        peek(1, v); chk(v == 32'd9,  "R5 dec", v, 32'd9);
        peek(1, v); chk(v == 32'd8,  "R5 dec", v, 32'd8);

        // R4: write while running is ignored
        cyc(1'b1, 1, 32'd99);
        peek(1, v); chk(v == 32'd6, "R4 busy write ignored", v, 32'd6);

        // R10: expiry six cycles later on bit 9 only
        hit_k = -1; hit_v = '0;
        for (int k = 1; k <= 10; k++) begin
            cyc(1'b0, 1, 32'h0);
            if (last_evt != 0 && hit_k < 0) begin
                hit_k = k; hit_v = last_evt;
            end
        end
        chk(hit_k == 6, "R10 expiry cycle", 32'(hit_k), 32'd6);
        chk(hit_v == 32'h0000_0200, "R10 cause bit 9", hit_v, 32'h0000_0200);

        // R9: one-shot stop state
        peek(4, v); chk(v == 32'h0, "R9 enable cleared", v, 32'h0);
        peek(1, v); chk(v == 32'h0, "R9 count zero", v, 32'h0);

        // R6: enable from zero reloads (reload untouched by busy write, R4)
        cyc(1'b1, 4, 32'h0000_0004);
        peek(1, v); chk(v == 32'd10, "R6 reload on enable / R4 reload kept", v, 32'd10);

        // R7: freeze and resume
        cyc(1'b1, 4, 32'h0);
        peek(1, v); chk(v == 32'd9, "R7 freeze", v, 32'd9);
        repeat (5) cyc(1'b0, 2, 32'h0);
        peek(1, v); chk(v == 32'd9, "R7 held", v, 32'd9);
        cyc(1'b1, 4, 32'h0000_0004);
        peek(1, v); chk(v == 32'd9, "R6 resume nonzero", v, 32'd9);
        peek(1, v); chk(v == 32'd8, "R7 resumed dec", v, 32'd8);
        cyc(1'b1, 4, 32'h0);

        // R8: periodic channel 2 with reload 4
        cyc(1'b1, 2, 32'd4);
        cyc(1'b1, 4, 32'h0000_0030);
        prev_hit = -1; n_hit = 0; gaps_ok = 1'b1;
        for (int k = 0; k < 16; k++) begin
            cyc(1'b0, 4, 32'h0);
            if (last_evt != 0) begin
                chk(last_evt == 32'h0000_0400, "R10 cause bit 10", last_evt, 32'h0000_0400);
                if (prev_hit >= 0 && k - prev_hit != 4) gaps_ok = 1'b0;
                prev_hit = k; n_hit++;
            end
        end
        chk(gaps_ok && n_hit >= 3, "R8 period", 32'(n_hit), 32'd3);
        peek(4, v); chk(v == 32'h0000_0030, "R8 still enabled", v, 32'h0000_0030);

        // R11: control layout and unmapped words
        cyc(1'b1, 4, 32'hFFFF_FFFF);
        peek(4, v); chk(v == 32'h0000_00FF, "R11 control bits", v, 32'h0000_00FF);
        cyc(1'b1, 4, 32'h0);
        peek(5, v); chk(v == 32'h0, "R11 unmapped 5", v, 32'h0);
        peek(7, v); chk(v == 32'h0, "R11 unmapped 7", v, 32'h0);
        cyc(1'b1, 3, 32'hFFFF_FFFF);
        peek(3, v); chk(v == 32'h00FF_FFFF, "R2 ch3 24-bit", v, 32'h00FF_FFFF);

        // Random phase, compared cycle by cycle against the model
        for (int n = 0; n < 6000; n++) begin
            int r = int'($urandom % 100);
            int ch = int'($urandom % 4);
            if (r < 2)       cyc(1'b1, ch, $urandom);
            else if (r < 10) cyc(1'b1, ch, 32'($urandom % 24));
            else if (r < 16) cyc(1'b1, 4, 32'($urandom & 32'hFF));
            else             cyc(1'b0, int'($urandom % 8), $urandom);
        end

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule